// File: doc/BRIEF.md
# Multiplexed-Address Parallel Bus Master

This block sits on the host side of a narrow parallel bus. Eight shared lines carry both a 16-bit address and an 8-bit data byte. The host hands over one request at a time on a valid/ready handshake. Each request carries a direction, an address, a write byte and a one-bit target select.

The master puts the address on the bus as two bytes, each qualified by its own latch strobe, low byte first. It then either drives the write byte or releases the lines for the target to drive. Next it pulls down the chosen chip select, and then the read or write strobe.

The access ends when the target's active-low acknowledge is seen through a two-flop synchroniser. If no acknowledge arrives, the access ends after a programmable number of cycles. Either way one response pulse returns the byte found on the lines and a timeout flag.

Top module: `mux_bus_master`

## Requirements
- R1: After reset, and whenever idle, both chip selects and the read and write strobes are high, both latch strobes are low, `req_ready` is high and `rsp_valid` is low.
- R2: A request is taken only while `req_ready` is high. `req_ready` stays low from the accepting edge until the response pulse has been given.
- R3: The access opens with `addr[7:0]` on `bus_dout` and `ale_lo` high for exactly STROBE_CYC cycles, followed by STROBE_CYC cycles with `ale_lo` low and the same byte held.
- R4: Next, `addr[15:8]` is driven with `ale_hi` high for exactly STROBE_CYC cycles, followed by STROBE_CYC cycles with `ale_hi` low.
- R5: `bus_oe` is high in every cycle except the data cycles of a read, which run from the end of the address phases to the end of the strobe. In a write, `bus_dout` carries the write byte while `wr_n` is low.
- R6: `req_target`=0 drives `cs0_n` low and `req_target`=1 drives `cs1_n` low, never both. The chip select falls STROBE_CYC+1 cycles after `ale_hi` falls and never overlaps a latch strobe.
- R7: `rd_n` (read, `req_write`=0) or `wr_n` (write, `req_write`=1) falls one cycle after the chip select, only while a chip select is low, and never both at once.
- R8: `ack_n` passes through two flops. The strobe ends on the edge where the synchronised acknowledge is first low, so an acknowledge driven d cycles into the strobe gives a strobe of d+4 cycles. The one-cycle response then has `rsp_timeout`=0 and `rsp_rdata` equal to `bus_din` at that edge.
- R9: If no acknowledge is seen, the strobe lasts exactly TIMEOUT_CYC cycles and the response has `rsp_timeout`=1. An acknowledge seen on the last allowed cycle still counts as success.
- R10: In the response cycle both chip selects and both strobes are already high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| req_target | input | 1 | Chip select choice (0 or 1) |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 8 | Byte sampled on the bus lines at completion |
| rsp_timeout | output | 1 | Access ended without acknowledge |
| bus_dout | output | 8 | Value driven on the shared lines |
| bus_oe | output | 1 | Drive enable for the shared lines |
| bus_din | input | 8 | Value read back from the shared lines |
| ale_lo | output | 1 | Low address byte latch strobe (active high) |
| ale_hi | output | 1 | High address byte latch strobe (active high) |
| cs0_n | output | 1 | Chip select 0, active low |
| cs1_n | output | 1 | Chip select 1, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ack_n | input | 1 | Target acknowledge, active low, asynchronous |

## Verification
The hardest cases to reach are the acknowledge that arrives on the very last cycle of the timeout window, and the one that arrives one cycle too late. From the ports these differ only by the target's response delay measured against the synchroniser latency. The bench's target model acknowledges a programmable number of cycles after the strobe falls. Directed cases set that delay to TIMEOUT_CYC-4 and TIMEOUT_CYC-3, so the two sides of the boundary are hit exactly. Random accesses mix delays, targets, directions and silent targets around them.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LO_SET,
    ST_LO_HOLD,
    ST_HI_SET,
    ST_HI_HOLD,
    ST_DATA,
    ST_SEL,
    ST_STROBE,
    ST_DONE
  } mbm_state_e;

  // Byte of the address placed on the shared lines in an address phase.
  function automatic logic [7:0] mbm_pick_byte(input logic [15:0] a, input logic upper);
    return upper ? a[15:8] : a[7:0];
  endfunction

  // Down-counter preload that makes a phase last n cycles.
  function automatic int unsigned mbm_hold_load(input int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

  // Phases in which the cycle timer is restarted on entry.
  function automatic logic mbm_is_timed(input mbm_state_e s);
    return (s == ST_LO_SET) || (s == ST_LO_HOLD) || (s == ST_HI_SET) ||
           (s == ST_HI_HOLD) || (s == ST_STROBE);
  endfunction
endpackage

// File: rtl/mbm_sync2.sv
module mbm_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/mbm_timer.sv
module mbm_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
  import mbm_pkg::*;
#(
  parameter int STROBE_CYC  = 4,
  parameter int TIMEOUT_CYC = 200000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  input  logic        req_target,
  output logic        rsp_valid,
  output logic [7:0]  rsp_rdata,
  output logic        rsp_timeout,
  output logic [7:0]  bus_dout,
  output logic        bus_oe,
  input  logic [7:0]  bus_din,
  output logic        ale_lo,
  output logic        ale_hi,
  output logic        cs0_n,
  output logic        cs1_n,
  output logic        rd_n,
  output logic        wr_n,
  input  logic        ack_n
);
  localparam int MAXC = (TIMEOUT_CYC > STROBE_CYC) ? TIMEOUT_CYC : STROBE_CYC;
  localparam int TW   = $clog2(MAXC + 1);
  localparam logic [TW-1:0] PH_LOAD = TW'(mbm_hold_load(STROBE_CYC));
  localparam logic [TW-1:0] TO_LOAD = TW'(mbm_hold_load(TIMEOUT_CYC));

  mbm_state_e state, nxt;

  logic        q_write, q_tgt;
  logic [15:0] q_addr;
  logic [7:0]  q_wdata;
  logic [7:0]  rdata_q;
  logic        to_q;

  // Named internal events
  logic ack_seen;     // synchronised acknowledge, active low
  logic tmr_exp;
  logic tmr_load;
  logic [TW-1:0] tmr_val;
  logic accept;
  logic in_data;      // data phase: DATA, SEL or STROBE
  logic sel_on;       // chip select window: SEL or STROBE

  mbm_sync2 #(.RST_VAL(1'b1)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(ack_n), .q(ack_seen)
  );

  mbm_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  assign accept = (state == ST_IDLE) && req_valid;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:    if (req_valid) nxt = ST_LO_SET;
      ST_LO_SET:  if (tmr_exp)   nxt = ST_LO_HOLD;
      ST_LO_HOLD: if (tmr_exp)   nxt = ST_HI_SET;
      ST_HI_SET:  if (tmr_exp)   nxt = ST_HI_HOLD;
      ST_HI_HOLD: if (tmr_exp)   nxt = ST_DATA;
      ST_DATA:                   nxt = ST_SEL;
      ST_SEL:                    nxt = ST_STROBE;
      ST_STROBE:  if (!ack_seen || tmr_exp) nxt = ST_DONE;
      ST_DONE:                   nxt = ST_IDLE;
      default:                   nxt = ST_IDLE;
    endcase
  end

  assign tmr_load = (nxt != state) && mbm_is_timed(nxt);
  assign tmr_val  = (nxt == ST_STROBE) ? TO_LOAD : PH_LOAD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_write <= 1'b0;
      q_tgt   <= 1'b0;
      q_addr  <= '0;
      q_wdata <= '0;
    end else if (accept) begin
      q_write <= req_write;
      q_tgt   <= req_target;
      q_addr  <= req_addr;
      q_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      to_q    <= 1'b0;
    end else if (state == ST_STROBE && nxt == ST_DONE) begin
      rdata_q <= bus_din;
      to_q    <= ack_seen;
    end
  end

  assign in_data = (state == ST_DATA) || (state == ST_SEL) || (state == ST_STROBE);
  assign sel_on  = (state == ST_SEL) || (state == ST_STROBE);

  always_comb begin
    unique case (state)
      ST_LO_SET, ST_LO_HOLD: bus_dout = mbm_pick_byte(q_addr, 1'b0);
      ST_HI_SET, ST_HI_HOLD: bus_dout = mbm_pick_byte(q_addr, 1'b1);
      ST_DATA, ST_SEL, ST_STROBE: bus_dout = q_write ? q_wdata : 8'h00;
      default:               bus_dout = 8'h00;
    endcase
  end

  assign bus_oe      = !(in_data && !q_write);
  assign ale_lo      = (state == ST_LO_SET);
  assign ale_hi      = (state == ST_HI_SET);
  assign cs0_n       = !(sel_on && !q_tgt);
  assign cs1_n       = !(sel_on && q_tgt);
  assign rd_n        = !((state == ST_STROBE) && !q_write);
  assign wr_n        = !((state == ST_STROBE) && q_write);
  assign req_ready   = (state == ST_IDLE);
  assign rsp_valid   = (state == ST_DONE);
  assign rsp_rdata   = rdata_q;
  assign rsp_timeout = to_q;
endmodule

// File: rtl/mbm_checker.sv
module mbm_checker #(
  parameter int TIMEOUT_CYC = 200000
) (
  input logic clk,
  input logic rst_n,
  input logic cs0_n,
  input logic cs1_n,
  input logic rd_n,
  input logic wr_n,
  input logic ale_lo,
  input logic ale_hi,
  input logic bus_oe,
  input logic req_ready,
  input logic rsp_valid,
  input logic rsp_timeout,
  input logic ack_seen
);
  logic [31:0] run_cnt;   // consecutive cycles with a strobe low

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_cnt <= '0;
    else if (!rd_n || !wr_n) run_cnt <= run_cnt + 1;
    else                     run_cnt <= '0;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs0_n && cs1_n && rd_n && wr_n && !ale_lo && !ale_hi && !rsp_valid));

  assert_single_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs0_n && !cs1_n));

  assert_latch_no_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_lo || ale_hi) |-> (cs0_n && cs1_n));

  assert_strobe_needs_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> (cs0_n != cs1_n));

  assert_strobe_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_read_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !bus_oe);

  assert_write_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> bus_oe);

  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_ack_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_timeout) |-> ($past(ack_seen) == 1'b0));

  assert_window_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= 32'(TIMEOUT_CYC));

  assert_timeout_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_timeout) |-> (run_cnt == 32'(TIMEOUT_CYC)));

  assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (cs0_n && cs1_n && rd_n && wr_n));
endmodule

bind mux_bus_master mbm_checker #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs0_n(cs0_n), .cs1_n(cs1_n), .rd_n(rd_n), .wr_n(wr_n),
  .ale_lo(ale_lo), .ale_hi(ale_hi), .bus_oe(bus_oe), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .ack_seen(ack_seen)
);

// File: tb/mux_bus_master_tb.sv
`timescale 1ns/1ps
module mux_bus_master_tb;
  localparam int S = 3;
  localparam int T = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_target = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, rsp_timeout, bus_oe, ale_lo, ale_hi;
  logic cs0_n, cs1_n, rd_n, wr_n;
  logic [7:0] rsp_rdata, bus_dout;
  logic [7:0] bus_din;
  logic ack_n;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mux_bus_master #(.STROBE_CYC(S), .TIMEOUT_CYC(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_target(req_target), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_timeout(rsp_timeout), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .bus_din(bus_din), .ale_lo(ale_lo), .ale_hi(ale_hi), .cs0_n(cs0_n),
    .cs1_n(cs1_n), .rd_n(rd_n), .wr_n(wr_n), .ack_n(ack_n)
  );

  // Data a target returns for a latched address.
  function automatic logic [7:0] tgt_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  // ---------------- target model ----------------
  bit mdl_dead = 1'b0;
  int mdl_dly = 0;
  logic [7:0] m_lo, m_hi;
  int mcnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_n <= 1'b1; bus_din <= 8'h00; mcnt <= 0; m_lo <= 8'h00; m_hi <= 8'h00;
    end else begin
      if (ale_lo) m_lo <= bus_dout;
      if (ale_hi) m_hi <= bus_dout;
      if ((!rd_n || !wr_n) && (cs0_n != cs1_n)) begin
        if (!mdl_dead && mcnt >= mdl_dly) begin
          ack_n <= 1'b0; bus_din <= tgt_byte({m_hi, m_lo});
        end
        mcnt <= mcnt + 1;
      end else begin
        ack_n <= 1'b1; bus_din <= 8'h3C; mcnt <= 0;
      end
    end
  end

  // ---------------- bus monitor ----------------
  bit mon_on = 1'b0;
  int n_lo, n_gap, n_hi, n_hihold, n_selpre, n_strobe, n_cs0, n_cs1;
  int n_busy_rdy, n_oe_bad, n_kind_bad, n_lo_bytebad, n_hi_bytebad, n_wd_bad;
  bit lo_seen, hi_seen, sel_seen, stb_seen;
  logic [15:0] mon_addr;
  logic [7:0]  mon_wd;
  logic        mon_wr;

  task automatic mon_clear();
    n_lo = 0; n_gap = 0; n_hi = 0; n_hihold = 0; n_selpre = 0; n_strobe = 0;
    n_cs0 = 0; n_cs1 = 0; n_busy_rdy = 0; n_oe_bad = 0; n_kind_bad = 0;
    n_lo_bytebad = 0; n_hi_bytebad = 0; n_wd_bad = 0;
    lo_seen = 0; hi_seen = 0; sel_seen = 0; stb_seen = 0;
  endtask

  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      if (req_ready && !req_valid && !rsp_valid) n_busy_rdy++;
      if (ale_lo) begin
        n_lo++; lo_seen = 1;
        if (bus_dout != mon_addr[7:0]) n_lo_bytebad++;
      end
      if (lo_seen && !ale_lo && !ale_hi && !hi_seen) begin
        n_gap++;
        if (bus_dout != mon_addr[7:0]) n_lo_bytebad++;
      end
      if (ale_hi) begin
        n_hi++; hi_seen = 1;
        if (bus_dout != mon_addr[15:8]) n_hi_bytebad++;
      end
      if (hi_seen && !ale_hi && cs0_n && cs1_n && !sel_seen) n_hihold++;
      if (!cs0_n) begin n_cs0++; sel_seen = 1; end
      if (!cs1_n) begin n_cs1++; sel_seen = 1; end
      if (sel_seen && rd_n && wr_n && !stb_seen && !(cs0_n && cs1_n)) n_selpre++;
      if (!rd_n || !wr_n) begin
        n_strobe++; stb_seen = 1;
        if ((!wr_n) != mon_wr) n_kind_bad++;
        if (bus_oe != mon_wr) n_oe_bad++;
        if (!wr_n && bus_dout != mon_wd) n_wd_bad++;
      end
      if (hi_seen && !ale_hi && !(cs0_n && cs1_n) == 1'b0 && !sel_seen && !bus_oe && mon_wr) n_oe_bad++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [15:0] a, input logic [7:0] wd,
                        input logic tg, input bit dead, input int dly);
    int waitc;
    bit exp_to;
    int exp_stb;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    mdl_dead = dead; mdl_dly = dly;
    mon_addr = a; mon_wd = wd; mon_wr = wr;
    mon_clear();
    mon_on = 1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_target = tg;
    @(negedge clk);
    req_valid = 1'b0;
    waitc = 0;
    while (!rsp_valid && waitc < 2000) begin @(negedge clk); waitc++; end
    mon_on = 0;
    chk(rsp_valid, "R8 response arrives", {31'd0, rsp_valid}, 1);
    exp_to  = dead || (dly + 4 > T);
    exp_stb = exp_to ? T : dly + 4;
    chk(rsp_timeout == exp_to, "R9 timeout flag", {31'd0, rsp_timeout}, {31'd0, exp_to});
    chk(n_strobe == exp_stb, exp_to ? "R9 strobe length" : "R8 strobe length", n_strobe, exp_stb);
    if (!wr && !exp_to)
      chk(rsp_rdata == tgt_byte(a), "R8 read data", rsp_rdata, tgt_byte(a));
    chk(n_lo == S && n_gap == S && n_lo_bytebad == 0, "R3 low address phase",
        {n_lo[7:0], n_gap[7:0], n_lo_bytebad[15:0]}, {8'(S), 8'(S), 16'd0});
    chk(n_hi == S && n_hi_bytebad == 0, "R4 high address phase",
        {n_hi[15:0], n_hi_bytebad[15:0]}, {16'(S), 16'd0});
    chk(n_hihold == S + 1, "R6 select delay", n_hihold, S + 1);
    chk((tg ? n_cs0 : n_cs1) == 0 && (tg ? n_cs1 : n_cs0) > 0, "R6 target select",
        {n_cs0[15:0], n_cs1[15:0]}, {15'd0, !tg, 15'd0, tg});
    chk(n_selpre == 1 && n_kind_bad == 0, "R7 strobe kind and order",
        {n_selpre[15:0], n_kind_bad[15:0]}, {16'd1, 16'd0});
    chk(n_oe_bad == 0 && n_wd_bad == 0, "R5 drive enable and write byte",
        {n_oe_bad[15:0], n_wd_bad[15:0]}, 0);
    chk(cs0_n && cs1_n && rd_n && wr_n, "R10 release at response",
        {28'd0, cs0_n, cs1_n, rd_n, wr_n}, 32'hF);
    chk(n_busy_rdy == 0, "R2 ready low while busy", n_busy_rdy, 0);
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R2 ready after response", {30'd0, req_ready, rsp_valid}, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs0_n && cs1_n && rd_n && wr_n && !ale_lo && !ale_hi, "R1 reset outputs",
        {26'd0, cs0_n, cs1_n, rd_n, wr_n, ale_lo, ale_hi}, 32'h3C);
    chk(req_ready && !rsp_valid, "R1 reset handshake", {30'd0, req_ready, rsp_valid}, 2);

    // directed corners
    access(1'b0, 16'h1234, 8'h00, 1'b0, 1'b0, 0);        // read, target 0
    access(1'b1, 16'hABCD, 8'h5E, 1'b1, 1'b0, 2);        // write, target 1
    access(1'b0, 16'h0000, 8'h00, 1'b1, 1'b0, 5);
    access(1'b1, 16'hFFFF, 8'hFF, 1'b0, 1'b0, 1);
    access(1'b0, 16'h8001, 8'h00, 1'b0, 1'b1, 0);        // silent target R9
    access(1'b0, 16'h4C2E, 8'h00, 1'b1, 1'b0, T - 4);    // ack on last cycle R9
    access(1'b1, 16'h7E81, 8'hA6, 1'b0, 1'b0, T - 3);    // one cycle late R9

    for (int i = 0; i < 40; i++) begin
      logic [31:0] r;
      r = $urandom;
      access(r[0], r[31:16], r[15:8], r[1], (r[4:2] == 3'd0), int'(r[7:5]) + int'(r[1]));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule